// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that lets a host read and write a bank of sixteen 8-bit registers over four wires: an active-low select, a serial clock, a data input and a data output. The host lowers select and sends one command byte. That byte gives the direction, a register number and a burst flag. One or more data bytes follow. Every byte travels least significant bit first. The host changes its data on the falling edge of the serial clock, and the port samples it on the rising edge. On a read the port changes its output on falling edges, so the host can sample it on the rising edge.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock edges are found by comparing successive synchronized samples. Raising select ends a transfer at once, in any state. The data output is driven only while a read is in progress, so the host may join the data input and output on one bidirectional pin. The writable registers appear in parallel on `regs_o`. Registers marked read-only by a parameter show the value of `stat_i` instead, and serial writes to them are refused.

Top module: `serial_reg_port`

## Requirements
- R1: While select (`sel_n`) is high, the port is idle: `sdo_oe` is 0 and `sdo` is high-impedance. Raising select ends any transfer at once, and the next low level of select starts over with a command byte.
- R2: Every byte is shifted least significant bit first. In the command byte, bit 0 is the direction (1 = read, 0 = write), bits 4..1 are the register number (bit 4 most significant), bits 6..5 are reserved, and bit 7 is the burst flag.
- R3: On a write, the 8 data bits after the command byte are stored into the addressed register, and the new value appears on `regs_o` bits [8*n+7 : 8*n]. `sdo_oe` stays 0 for the whole write.
- R4: On a read, the addressed register is put on `sdo` one bit per falling edge of `sclk`, starting with the first falling edge after the command byte. Each bit is valid at the next rising edge.
- R5: A command byte whose bits 6..5 are not both zero is ignored. No register changes, and `sdo_oe` stays 0 until select rises.
- R6: A write takes effect only after all 8 data bits have been sampled. If select rises before the 8th rising edge, or is seen high in the same system clock cycle as that edge, the byte is discarded.
- R7: The burst flag with register number 0 makes successive bytes read or write registers 0, 1, 2 and onward. After register 15 the sequence wraps to register 0, and it continues until select rises.
- R8: The burst flag with a nonzero register number has no effect, and the transfer moves a single byte. Bytes after the first one are ignored.
- R9: A register whose bit is set in `RO_MASK` (default: registers 12 to 15) reads as its slice of `stat_i` and shows that slice on `regs_o`. Serial writes to it are ignored.
- R10: After reset, every writable register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Transfer select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host; high-impedance when not driven |
| sdo_oe | output | 1 | 1 while `sdo` is driven |
| stat_i | input | 128 | Parallel values of the read-only registers, 8 bits per register |
| regs_o | output | 128 | Parallel view of all sixteen registers |

## Verification
The host can raise select in the very system clock cycle in which the synchronizer presents the 8th rising edge of a data byte. In that cycle, completing a write and aborting the transfer compete. The bench provokes this by driving the 8th rising edge of `sclk` and the rising edge of `sel_n` on the same clock edge, so both pass through equal synchronizer delays. The bench then checks on `regs_o` that the register kept its old value, because the abort takes priority. The same pairing is tried against a normal completed byte, which must be stored.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter logic [15:0] RO_MASK = 16'hF000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic [127:0] stat_i,
  output logic [127:0] regs_o
);
  localparam int NREG = 16;
  localparam int DW   = 8;
  localparam int AW   = 4;

  typedef enum logic [1:0] {P_CMD, P_DATA, P_DONE, P_SKIP} phase_t;

  logic [1:0] sel_sy;
  logic [2:0] sclk_sy;
  logic [1:0] sdi_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_sy  <= 2'b11;
      sclk_sy <= 3'b111;
      sdi_sy  <= 2'b00;
    end else begin
      sel_sy  <= {sel_sy[0], sel_n};
      sclk_sy <= {sclk_sy[1:0], sclk};
      sdi_sy  <= {sdi_sy[0], sdi};
    end

  wire deselect = sel_sy[1];
  wire rise     = sclk_sy[1] & ~sclk_sy[2];
  wire fall     = ~sclk_sy[1] & sclk_sy[2];
  wire din      = sdi_sy[1];

  phase_t        phase;
  logic [2:0]    bcnt, fcnt;
  logic [6:0]    sh;
  logic [AW-1:0] addr;
  logic          rd, burst, sdo_q, oe_q;
  logic [DW-1:0] tx;
  logic [DW-1:0] view [NREG];

  wire [7:0]    byte_in  = {din, sh};
  wire          byte_end = rise && (bcnt == 3'd7);
  wire [AW-1:0] cmd_addr = byte_in[4:1];
  wire [AW-1:0] addr_nx  = addr + 4'd1;
  wire          wr_en    = !deselect && (phase == P_DATA) && !rd && byte_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_CMD;
      bcnt  <= '0;
      fcnt  <= '0;
      sh    <= '0;
      addr  <= '0;
      rd    <= 1'b0;
      burst <= 1'b0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
      tx    <= '0;
    end else if (deselect) begin
      phase <= P_CMD;
      bcnt  <= '0;
      fcnt  <= '0;
      rd    <= 1'b0;
      burst <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (rise) begin
        sh   <= byte_in[7:1];
        bcnt <= bcnt + 3'd1;
      end
      case (phase)
        P_CMD:
          if (byte_end) begin
            if (byte_in[6:5] != 2'b00) phase <= P_SKIP;
            else begin
              phase <= P_DATA;
              addr  <= cmd_addr;
              rd    <= byte_in[0];
              burst <= byte_in[7] && (cmd_addr == '0);
              tx    <= view[cmd_addr];
              fcnt  <= '0;
            end
          end
        P_DATA:
          if (rd) begin
            if (fall) begin
              sdo_q <= tx[0];
              tx    <= {1'b0, tx[DW-1:1]};
              oe_q  <= 1'b1;
              fcnt  <= fcnt + 3'd1;
              if (fcnt == 3'd7) begin
                if (burst) begin
                  addr <= addr_nx;
                  tx   <= view[addr_nx];
                end else phase <= P_DONE;
              end
            end
          end else if (byte_end) begin
            if (burst) addr <= addr_nx;
            else phase <= P_DONE;
          end
        P_DONE:
          if (fall) oe_q <= 1'b0;
        default: ;
      endcase
    end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (RO_MASK[i]) begin : g_ro
      assign view[i] = stat_i[i*DW +: DW];
    end else begin : g_rw
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= '0;
        else if (wr_en && addr == AW'(i)) r <= byte_in;
      assign view[i] = r;
    end
    assign regs_o[i*DW +: DW] = view[i];
  end

  assign sdo_oe = oe_q;
  assign sdo    = oe_q ? sdo_q : 1'bz;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         deselect,
  input logic         rise,
  input logic         fall,
  input logic         oe,
  input logic         rd,
  input logic [1:0]   phase,
  input logic         sdo_q,
  input logic [127:0] regs_o,
  input logic [127:0] stat_i
);
  assert_hiz_on_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    deselect |=> !oe);

  assert_drive_only_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rd);

  assert_write_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(regs_o) || !$stable(stat_i)));

  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q));

  assert_skip_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |-> !oe);

  assert_skip_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |=> ($stable(regs_o) || !$stable(stat_i)));
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .deselect(deselect), .rise(rise), .fall(fall),
  .oe(oe_q), .rd(rd), .phase(phase), .sdo_q(sdo_q), .regs_o(regs_o), .stat_i(stat_i)
);

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, sel_n = 1, sclk = 1, sdi = 0;
  logic [127:0] stat_i, regs_o;
  wire sdo, sdo_oe;
  int checks = 0, fails = 0;
  logic [7:0] expv [16];
  logic [7:0] rx, oem;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port dut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .stat_i(stat_i), .regs_o(regs_o));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_x();
    sel_n = 0; wait_clk(H);
  endtask

  task automatic end_x();
    wait_clk(H); sel_n = 1; wait_clk(6);
  endtask

  task automatic shift_n(input logic [7:0] d, input int n);
    rx = '0; oem = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 0; sdi = d[i];
      wait_clk(H);
      rx[i] = sdo; oem[i] = sdo_oe;
      sclk = 1;
      wait_clk(H);
    end
  endtask

  task automatic shift(input logic [7:0] d);
    shift_n(d, 8);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++)
      check(reg_at(i) === expv[i], req, reg_at(i), expv[i]);
  endtask

  task automatic t_reset();
    check(sdo_oe === 1'b0, "R1 reset oe", {7'd0, sdo_oe}, 8'h00);
    for (int i = 0; i < 12; i++) expv[i] = 8'h00;
    for (int i = 12; i < 16; i++) expv[i] = stat_i[i*8 +: 8];
    check_all("R10 reset registers");
  endtask

  task automatic t_write_read();
    start_x(); shift(8'h06); shift(8'hA5);
    check(oem == 8'h00, "R3 no drive during write", oem, 8'h00);
    end_x(); expv[3] = 8'hA5;
    check(reg_at(3) === 8'hA5, "R3 write reg3", reg_at(3), 8'hA5);
    start_x(); shift(8'h02); shift(8'h01); end_x(); expv[1] = 8'h01;
    check(reg_at(1) === 8'h01, "R2 lsb first", reg_at(1), 8'h01);
    start_x(); shift(8'h07); shift(8'h00);
    check(rx === 8'hA5, "R4 read reg3", rx, 8'hA5);
    check(oem == 8'hFF, "R4 drive during read", oem, 8'hFF);
    end_x();
    check(sdo_oe === 1'b0, "R1 released after select", {7'd0, sdo_oe}, 8'h00);
  endtask

  task automatic t_reserved();
    start_x(); shift(8'h2C); shift(8'hFF); end_x();
    check(reg_at(6) === expv[6], "R5 reserved write ignored", reg_at(6), expv[6]);
    start_x(); shift(8'h47); shift(8'h00);
    check(oem == 8'h00, "R5 reserved read not driven", oem, 8'h00);
    end_x();
  endtask

  task automatic t_abort();
    start_x(); shift(8'h0A); shift_n(8'hFF, 5); sel_n = 1; wait_clk(6);
    sclk = 1; wait_clk(H);
    check(reg_at(5) === expv[5], "R6 partial byte dropped", reg_at(5), expv[5]);
    start_x(); shift(8'h0A); shift_n(8'hFF, 7);
    sclk = 0; sdi = 1; wait_clk(H);
    sclk = 1; sel_n = 1; wait_clk(8);
    check(reg_at(5) === expv[5], "R6 deselect with 8th edge", reg_at(5), expv[5]);
    start_x(); shift(8'h0A); shift(8'h5C); end_x(); expv[5] = 8'h5C;
    check(reg_at(5) === 8'h5C, "R1 restart after abort", reg_at(5), 8'h5C);
  endtask

  task automatic t_burst();
    start_x(); shift(8'h80);
    for (int k = 0; k < 17; k++) begin
      shift(8'h11 + 8'(k * 7));
      if (k < 12 || k == 16) expv[k % 16] = 8'h11 + 8'(k * 7);
    end
    end_x();
    check_all("R7 burst write with wrap / R9 ro kept");
    start_x(); shift(8'h81);
    for (int k = 0; k < 17; k++) begin
      shift(8'h00);
      check(rx === expv[k % 16], "R7 burst read with wrap", rx, expv[k % 16]);
    end
    end_x();
  endtask

  task automatic t_burst_nonzero();
    start_x(); shift(8'h84); shift(8'h3E); shift(8'h77); end_x(); expv[2] = 8'h3E;
    check(reg_at(2) === 8'h3E, "R8 first byte", reg_at(2), 8'h3E);
    check(reg_at(3) === expv[3], "R8 no advance", reg_at(3), expv[3]);
    start_x(); shift(8'h0E); shift(8'h3C); shift(8'hC3); end_x(); expv[7] = 8'h3C;
    check(reg_at(7) === 8'h3C, "R3 single write", reg_at(7), 8'h3C);
    check(reg_at(8) === expv[8], "R8 extra byte ignored", reg_at(8), expv[8]);
  endtask

  task automatic t_readonly();
    start_x(); shift(8'h1A); shift(8'h00); end_x();
    check(reg_at(13) === stat_i[13*8 +: 8], "R9 ro write ignored", reg_at(13), stat_i[13*8 +: 8]);
    start_x(); shift(8'h1B); shift(8'h00); end_x();
    check(rx === stat_i[13*8 +: 8], "R9 ro read", rx, stat_i[13*8 +: 8]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) stat_i[i*8 +: 8] = 8'hC0 + 8'(i * 3);
    wait_clk(4); rst_n = 1; wait_clk(4);
    t_reset();
    t_write_read();
    t_reserved();
    t_abort();
    t_burst();
    t_burst_nonzero();
    t_readonly();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule